// File: doc/BRIEF.md
# Serial Configuration Register Target

This block lets a host controller program a small bank of configuration registers over a two-wire SMBus-style link. A fast system clock oversamples the clock line and the data line through two-flop synchronizers. The block finds bus start and stop conditions from the sampled waveforms and shifts bytes in, most significant bit first. It answers each accepted byte by pulling the data line low during the ninth clock. The data line is open drain, so the block only drives a low-enable output (`sda_pull`), and a pull-up on the board supplies the high level.

A transaction has three parts. The first byte carries a 7-bit device address and a direction bit. The second byte sets an internal register pointer. Every byte after that is written to the register the pointer names, and the pointer then steps by one. A chip-select input gates the whole interface, so several identical targets can share one clock and data pair. If both lines stay high for too long, the transaction is abandoned and the block returns to idle.

All register contents are presented in parallel on `cfg_regs`. Two of the register bits drive power-down controls: one for the input buffers and one for the output buffer. Reads, address resolution and packet error checking are not provided.

Top module: `cfg_smbus_target`

## Requirements
- R1: A falling SDA while SCL is high (START) begins address reception. A rising SDA while SCL is high (STOP) ends the transaction. Bytes clocked after a STOP without a new START get no acknowledge and write nothing.
- R2: The first byte after START is matched MSB first. Bits [7:1] must equal the parameter DEV_ADDR (default 0x5D) and bit 0 must be 0 (write). A matching byte is acknowledged. Any other byte, including one with bit 0 = 1, gets no acknowledge, and the block ignores the bus until the next START or STOP.
- R3: After an acknowledged address, the next byte loads the register pointer and is acknowledged. Each following byte is acknowledged and written to the register at the pointer. The pointer then increments by one, wrapping from 0xFF to 0x00.
- R4: A data byte whose pointer is N_REGS (default 48) or above is acknowledged but discarded. The pointer still increments.
- R5: `sda_pull` is high only from the SCL falling edge that ends the eighth bit of an accepted byte to the SCL falling edge that ends the ninth clock.
- R6: While `cs` is low, `sda_pull` stays low and no register changes. If `cs` rises in the middle of a frame, nothing is accepted until a new START.
- R7: A repeated START in the middle of a transaction discards any partial byte and restarts address reception. Bits shifted before it write nothing.
- R8: If SCL and SDA are both high for TIMEOUT_CYC (default 200) system clocks in the middle of a transaction, the block goes idle. Later bytes sent without a START get no acknowledge and write nothing.
- R9: `in_buf_off` follows bit 6 of register 0x26, so writing 0x40 there sets it. `out_buf_pd` follows bit 4 of register 0x01, so writing 0x10 there sets it. Each changes only through a register write.
- R10: Register i appears on `cfg_regs[8*i+7:8*i]`. After reset every register is 0x00, `sda_pull` is low, and both power-down outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select; the interface responds only while high |
| scl_in | input | 1 | Bus clock line as sampled at the pad |
| sda_in | input | 1 | Bus data line as sampled at the pad |
| sda_pull | output | 1 | Open-drain enable; high pulls the data line low |
| cfg_regs | output | N_REGS*8 | All configuration registers, register i in byte lane i |
| in_buf_off | output | 1 | Input-buffer disable, from register 0x26 bit 6 |
| out_buf_pd | output | 1 | Output-buffer power-down, from register 0x01 bit 4 |

## Verification
The hardest state to reach is a transaction that is abandoned partway through. Examples are a repeated START after only a few data bits, a clock-high stall that outlasts the timeout, and a chip select that rises after the address byte has already gone by. Each of these needs a host model that can stop a byte at any bit and hold the lines in a chosen state for a chosen number of cycles. The bench therefore builds its host from single-bit, start and stop primitives rather than from whole frames. Randomly addressed and randomly placed bursts run alongside these cases, so pointer wrap, out-of-range discards and mismatched addresses occur mixed with good traffic.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

  typedef enum logic [2:0] {
    LNK_IDLE,
    LNK_RECV,
    LNK_ACK_WAIT,
    LNK_ACK_HOLD,
    LNK_IGNORE
  } link_state_t;

  typedef enum logic [1:0] {
    ROLE_ADDR,
    ROLE_PTR,
    ROLE_DATA
  } byte_role_t;

  // A device byte is accepted when its upper seven bits match and it is a write.
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return (b[7:1] == dev) && (b[0] == 1'b0);
  endfunction

  // Pointer advance, wrapping at the byte boundary.
  function automatic logic [7:0] ptr_next(input logic [7:0] p);
    return 8'(p + 8'd1);
  endfunction

  // A pointer addresses a real register only below the bank size.
  function automatic logic ptr_in_bank(input logic [7:0] p, input int unsigned n);
    return int'(p) < int'(n);
  endfunction

endpackage

// File: rtl/cfgbus_sync_bit.sv
module cfgbus_sync_bit #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/cfgbus_line_watch.sv
module cfgbus_line_watch #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TIMEOUT_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic cs_in,
  output logic scl_q,
  output logic sda_q,
  output logic sel_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt,
  output logic idle_evt
);

  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);

  logic scl_p, sda_p;
  logic both_high;
  logic [CW-1:0] high_cnt;

  cfgbus_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_q));
  cfgbus_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_q));
  cfgbus_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sel (
    .clk(clk), .rst_n(rst_n), .d(cs_in), .q(sel_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_q;
      sda_p <= sda_q;
    end
  end

  assign scl_rise  =  scl_q & ~scl_p;
  assign scl_fall  = ~scl_q &  scl_p;
  assign start_evt =  scl_q &  scl_p &  sda_p & ~sda_q;
  assign stop_evt  =  scl_q &  scl_p & ~sda_p &  sda_q;

  // High-time watchdog: counts while both lines rest high, fires once per stretch.
  assign both_high = scl_q & sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_cnt <= '0;
    end else if (!both_high) begin
      high_cnt <= '0;
    end else if (high_cnt != CW'(TIMEOUT_CYC)) begin
      high_cnt <= high_cnt + 1'b1;
    end
  end

  assign idle_evt = both_high && (high_cnt == CW'(TIMEOUT_CYC - 1));

endmodule

// File: rtl/cfgbus_frame_fsm.sv
module cfgbus_frame_fsm
  import cfgbus_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h5D,
  parameter int unsigned N_REGS   = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_q,
  input  logic       sda_q,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       idle_evt,
  output logic       ack_drv,
  output logic       wr_en,
  output logic [7:0] wr_ptr,
  output logic [7:0] wr_data,
  output logic       data_done,
  output logic [2:0] bit_cnt
);

  link_state_t state;
  byte_role_t  role;
  logic [6:0]  shreg;
  logic [7:0]  ptr;
  logic [7:0]  byte_now;
  logic        byte_done;
  logic        take;

  assign byte_now  = {shreg, sda_q};
  assign byte_done = sel_q && (state == LNK_RECV) && scl_rise && (bit_cnt == 3'd7);
  assign take      = (role != ROLE_ADDR) || addr_hit(byte_now, DEV_ADDR);
  assign data_done = byte_done && (role == ROLE_DATA);
  assign wr_en     = data_done && ptr_in_bank(ptr, N_REGS);
  assign wr_ptr    = ptr;
  assign wr_data   = byte_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= LNK_IDLE;
      role    <= ROLE_ADDR;
      shreg   <= '0;
      ptr     <= '0;
      bit_cnt <= '0;
      ack_drv <= 1'b0;
    end else if (!sel_q) begin
      state   <= LNK_IDLE;
      bit_cnt <= '0;
      ack_drv <= 1'b0;
    end else if (start_evt) begin
      state   <= LNK_RECV;
      role    <= ROLE_ADDR;
      bit_cnt <= '0;
      ack_drv <= 1'b0;
    end else if (stop_evt || idle_evt) begin
      state   <= LNK_IDLE;
      bit_cnt <= '0;
      ack_drv <= 1'b0;
    end else begin
      unique case (state)
        LNK_RECV: begin
          if (scl_rise) begin
            shreg <= byte_now[6:0];
            if (bit_cnt == 3'd7) begin
              bit_cnt <= '0;
              state   <= take ? LNK_ACK_WAIT : LNK_IGNORE;
              unique case (role)
                ROLE_ADDR: role <= ROLE_PTR;
                ROLE_PTR: begin
                  ptr  <= byte_now;
                  role <= ROLE_DATA;
                end
                ROLE_DATA: ptr <= ptr_next(ptr);
                default: role <= ROLE_ADDR;
              endcase
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
            end
          end
        end
        LNK_ACK_WAIT: begin
          if (scl_fall) begin
            ack_drv <= 1'b1;
            state   <= LNK_ACK_HOLD;
          end
        end
        LNK_ACK_HOLD: begin
          if (scl_fall) begin
            ack_drv <= 1'b0;
            state   <= LNK_RECV;
          end
        end
        default: begin
          ack_drv <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/cfgbus_reg_file.sv
module cfgbus_reg_file #(
  parameter int unsigned N_REGS   = 48,
  parameter int unsigned IBUF_REG = 8'h26,
  parameter int unsigned IBUF_BIT = 6,
  parameter int unsigned OBUF_REG = 8'h01,
  parameter int unsigned OBUF_BIT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [7:0]          wr_ptr,
  input  logic [7:0]          wr_data,
  output logic [N_REGS*8-1:0] regs_flat,
  output logic                in_buf_off,
  output logic                out_buf_pd
);

  generate
    for (genvar i = 0; i < N_REGS; i++) begin : g_reg
      logic [7:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= 8'h00;
        else if (wr_en && (wr_ptr == 8'(i))) r_q <= wr_data;
      end
      assign regs_flat[i*8 +: 8] = r_q;
    end

    if (IBUF_REG < N_REGS) begin : g_ibuf
      assign in_buf_off = regs_flat[IBUF_REG*8 + IBUF_BIT];
    end else begin : g_ibuf_none
      assign in_buf_off = 1'b0;
    end

    if (OBUF_REG < N_REGS) begin : g_obuf
      assign out_buf_pd = regs_flat[OBUF_REG*8 + OBUF_BIT];
    end else begin : g_obuf_none
      assign out_buf_pd = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/cfg_smbus_target.sv
module cfg_smbus_target #(
  parameter logic [6:0]  DEV_ADDR    = 7'h5D,
  parameter int unsigned N_REGS      = 48,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TIMEOUT_CYC = 200
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs,
  input  logic                scl_in,
  input  logic                sda_in,
  output logic                sda_pull,
  output logic [N_REGS*8-1:0] cfg_regs,
  output logic                in_buf_off,
  output logic                out_buf_pd
);

  logic       scl_q, sda_q, sel_q;
  logic       scl_rise, scl_fall;
  logic       start_evt, stop_evt, idle_evt;
  logic       wr_en, data_done;
  logic [7:0] wr_ptr, wr_data;
  logic [2:0] bit_cnt;

  cfgbus_line_watch #(
    .SYNC_STAGES(SYNC_STAGES),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_watch (
    .clk(clk), .rst_n(rst_n),
    .scl_in(scl_in), .sda_in(sda_in), .cs_in(cs),
    .scl_q(scl_q), .sda_q(sda_q), .sel_q(sel_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .idle_evt(idle_evt)
  );

  cfgbus_frame_fsm #(
    .DEV_ADDR(DEV_ADDR),
    .N_REGS(N_REGS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .sel_q(sel_q), .sda_q(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .idle_evt(idle_evt),
    .ack_drv(sda_pull),
    .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_data),
    .data_done(data_done), .bit_cnt(bit_cnt)
  );

  cfgbus_reg_file #(
    .N_REGS(N_REGS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_data),
    .regs_flat(cfg_regs),
    .in_buf_off(in_buf_off), .out_buf_pd(out_buf_pd)
  );

endmodule

// File: rtl/cfg_smbus_target_chk.sv
module cfg_smbus_target_chk #(
  parameter int unsigned N_REGS = 48
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_q,
  input logic       scl_q,
  input logic       start_evt,
  input logic       idle_evt,
  input logic       data_done,
  input logic       wr_en,
  input logic [7:0] wr_ptr,
  input logic [2:0] bit_cnt,
  input logic       sda_pull,
  input logic       in_buf_off,
  input logic       out_buf_pd
);

  // R5: while selected, the pull only switches during the low phase of SCL.
  assert_pull_edge_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && $past(sel_q) && !$stable(sda_pull)) |-> !scl_q);

  // R6: once deselection has settled, the line is never pulled.
  assert_deselect_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_q && !$past(sel_q)) |-> !sda_pull);

  // R3: every completed data byte advances the pointer by exactly one.
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_done |=> (wr_ptr == 8'($past(wr_ptr) + 8'd1)));

  // R3: register writes land while SCL is high (on the eighth sample).
  assert_write_on_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> scl_q);

  // R7: a START clears the bit counter and the pull.
  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && start_evt) |=> ((bit_cnt == 3'd0) && !sda_pull));

  // R8: a timeout leaves the line released.
  assert_timeout_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && idle_evt) |=> !sda_pull);

  // R9: power-down outputs move only after a register write.
  assert_pd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(in_buf_off) && $stable(out_buf_pd)));

endmodule

bind cfg_smbus_target cfg_smbus_target_chk #(.N_REGS(N_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .scl_q(scl_q),
  .start_evt(start_evt), .idle_evt(idle_evt), .data_done(data_done),
  .wr_en(wr_en), .wr_ptr(wr_ptr), .bit_cnt(bit_cnt), .sda_pull(sda_pull),
  .in_buf_off(in_buf_off), .out_buf_pd(out_buf_pd)
);

// File: tb/sim_cfg_smbus_target.sv
`timescale 1ns/1ps
module sim_cfg_smbus_target;

  localparam logic [6:0] DEV = 7'h5D;
  localparam int NR = 48;
  localparam int NB = NR * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b1;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_line;
  logic sda_pull;
  logic [NB-1:0] cfg_regs;
  logic in_buf_off, out_buf_pd;

  int checks = 0;
  int fails = 0;
  int viol = 0;
  bit ack_win = 1'b0;
  bit finished = 1'b0;
  logic [7:0] model [NR];
  logic [7:0] dbuf [8];

  always #5 clk = ~clk;

  assign sda_line = sda_h & ~sda_pull;

  cfg_smbus_target u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs),
    .scl_in(scl_h), .sda_in(sda_line),
    .sda_pull(sda_pull), .cfg_regs(cfg_regs),
    .in_buf_off(in_buf_off), .out_buf_pd(out_buf_pd)
  );

  // R5: the pull may only appear inside the host's acknowledge slot.
  always @(negedge clk) if (rst_n && sda_pull && !ack_win) viol++;

  function automatic bit exp_addr_ok(input logic [7:0] b);
    return (b[7:1] == DEV) && !b[0];
  endfunction

  function automatic logic [NB-1:0] exp_flat();
    logic [NB-1:0] f;
    for (int i = 0; i < NR; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [NB-1:0] act,
                     input logic [NB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; w(4); scl_h = 1'b1; w(8);
    sda_h = 1'b0; w(8); scl_h = 1'b0; w(4);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; w(4); scl_h = 1'b1; w(8); sda_h = 1'b1; w(8);
  endtask

  task automatic send_bit(input logic b);
    sda_h = b; w(4); scl_h = 1'b1; w(8); scl_h = 1'b0; w(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; w(4); scl_h = 1'b1; w(8); scl_h = 1'b0;
      if (i == 0) ack_win = 1'b1;
      w(4);
    end
    sda_h = 1'b1; w(4); scl_h = 1'b1; w(4);
    acked = !sda_line;
    w(4); scl_h = 1'b0; w(4);
    ack_win = 1'b0;
  endtask

  task automatic byte_expect(input logic [7:0] b, input bit exp_ack, input string req);
    bit a;
    send_byte(b, a);
    chk(a == exp_ack, req, NB'(a), NB'(exp_ack));
  endtask

  task automatic check_state(input string req);
    chk(cfg_regs === exp_flat(), req, cfg_regs, exp_flat());
    chk(in_buf_off === model[8'h26][6], "R9 in_buf_off", NB'(in_buf_off), NB'(model[8'h26][6]));
    chk(out_buf_pd === model[8'h01][4], "R9 out_buf_pd", NB'(out_buf_pd), NB'(model[8'h01][4]));
  endtask

  // Full write frame; expected acks and register effects come from the model.
  task automatic do_write(input logic [7:0] ab, input logic [7:0] p, input int n,
                          input string req);
    bit live;
    logic [7:0] q;
    live = cs && exp_addr_ok(ab);
    bus_start();
    byte_expect(ab, live, req);
    byte_expect(p, live, req);
    q = p;
    for (int k = 0; k < n; k++) begin
      byte_expect(dbuf[k], live, req);
      if (live) begin
        if (int'(q) < NR) model[q] = dbuf[k];
        q = 8'(q + 8'd1);
      end
    end
    bus_stop();
    w(4);
    check_state(req);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) model[i] = 8'h00;
    void'($urandom(32'd20240611));
    w(5);
    // R10: reset state
    chk(cfg_regs === '0, "R10 regs after reset", cfg_regs, '0);
    chk(sda_pull === 1'b0, "R10 pull after reset", NB'(sda_pull), '0);
    chk(!in_buf_off && !out_buf_pd, "R10 pd after reset",
        NB'({in_buf_off, out_buf_pd}), '0);
    rst_n = 1'b1;
    w(10);

    // R9: input-buffer disable through register 0x26
    dbuf[0] = 8'h40;
    do_write({DEV, 1'b0}, 8'h26, 1, "R9 write 0x26");
    chk(in_buf_off === 1'b1, "R9 in_buf_off set", NB'(in_buf_off), NB'(1));
    // R3 R9: burst from 0x00 sets 0x01 = 0x10
    dbuf[0] = 8'hA5; dbuf[1] = 8'h10; dbuf[2] = 8'h3C;
    do_write({DEV, 1'b0}, 8'h00, 3, "R3 burst");
    chk(out_buf_pd === 1'b1, "R9 out_buf_pd set", NB'(out_buf_pd), NB'(1));
    dbuf[0] = 8'h00;
    do_write({DEV, 1'b0}, 8'h26, 1, "R9 clear 0x26");

    // R2: wrong address and read direction are not acknowledged
    dbuf[0] = 8'hFF;
    do_write({7'h2A, 1'b0}, 8'h04, 1, "R2 wrong address");
    do_write({DEV, 1'b1}, 8'h04, 1, "R2 read bit");

    // R4: out-of-range pointer and crossing the bank end
    dbuf[0] = 8'h77;
    do_write({DEV, 1'b0}, 8'h40, 1, "R4 out of range");
    dbuf[0] = 8'h11; dbuf[1] = 8'h22;
    do_write({DEV, 1'b0}, 8'h2F, 2, "R4 bank end");
    // R3: pointer wrap from 0xFF to 0x00
    dbuf[0] = 8'h99; dbuf[1] = 8'h5E;
    do_write({DEV, 1'b0}, 8'hFF, 2, "R3 pointer wrap");

    // R6: deselected frame
    cs = 1'b0; w(4);
    dbuf[0] = 8'hEE;
    do_write({DEV, 1'b0}, 8'h02, 1, "R6 deselected");
    // R6: select rises after address byte
    bus_start();
    byte_expect({DEV, 1'b0}, 1'b0, "R6 late select addr");
    cs = 1'b1; w(4);
    byte_expect(8'h03, 1'b0, "R6 late select ptr");
    byte_expect(8'hD1, 1'b0, "R6 late select data");
    bus_stop(); w(4);
    check_state("R6 late select regs");

    // R1: bytes after STOP without START are ignored
    scl_h = 1'b0; w(4);
    byte_expect({DEV, 1'b0}, 1'b0, "R1 no start addr");
    byte_expect(8'h04, 1'b0, "R1 no start ptr");
    byte_expect(8'h6B, 1'b0, "R1 no start data");
    bus_stop(); w(4);
    check_state("R1 no start regs");

    // R7: repeated START after three data bits
    bus_start();
    byte_expect({DEV, 1'b0}, 1'b1, "R7 addr");
    byte_expect(8'h05, 1'b1, "R7 ptr");
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    byte_expect({DEV, 1'b0}, 1'b1, "R7 restart addr");
    byte_expect(8'h06, 1'b1, "R7 restart ptr");
    byte_expect(8'h3C, 1'b1, "R7 restart data");
    model[6] = 8'h3C;
    bus_stop(); w(4);
    check_state("R7 regs");

    // R8: high stall beyond the timeout abandons the frame
    bus_start();
    byte_expect({DEV, 1'b0}, 1'b1, "R8 addr");
    byte_expect(8'h07, 1'b1, "R8 ptr");
    sda_h = 1'b1; w(4); scl_h = 1'b1; w(300); scl_h = 1'b0; w(4);
    byte_expect(8'hAA, 1'b0, "R8 after timeout");
    bus_stop(); w(4);
    check_state("R8 regs");

    // Random traffic: R2 R3 R4
    for (int t = 0; t < 30; t++) begin
      logic [7:0] ab, p;
      int n;
      ab = ($urandom % 4 == 0) ? 8'($urandom) : {DEV, 1'b0};
      p  = 8'($urandom % 56);
      if ($urandom % 8 == 0) p = 8'hFE;
      n  = 1 + int'($urandom % 4);
      for (int k = 0; k < n; k++) dbuf[k] = 8'($urandom);
      do_write(ab, p, n, "R3 random");
    end

    chk(viol == 0, "R5 pull outside ack slot", NB'(viol), '0);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule